// File: doc/BRIEF.md
# Serial Delay-Code Loader

This block is the configuration port for a two-channel programmable delay unit. Three wires drive it: a serial data line, a serial clock and a load strobe. Bits shift into an 11-bit frame register. When the strobe is raised, the frame passes into one of two 9-bit delay-code registers and into a shared mode flag. The two codes and the flag go to a downstream delay datapath.

The serial clock, the serial data and the strobe are sampled in the system clock domain through two-flop synchronizers. A rising edge of the synchronized serial clock shifts the frame register once. The serial clock must therefore run well below the system clock. A holding state machine has two states:
- `LD_IDLE` holds the outputs.
- `LD_FOLLOW` copies the frame into the addressed channel and the mode flag on every system clock, which makes the holding registers transparent.

The machine moves from `LD_IDLE` to `LD_FOLLOW` when the synchronized strobe is high. It moves from `LD_FOLLOW` back to `LD_IDLE` when the synchronized strobe is low, and the last value copied is the one that stays frozen.

Top module: `dlycfg_loader`

## Requirements
- R1: While reset is asserted, and right after it is released, both delay codes and the mode flag read 0. The frame register is also cleared, so a strobe given without any shifting loads code 0 into channel 0 and clears the mode flag.
- R2: Each rising edge of the serial clock shifts the frame register by one place. The new bit is the serial data value sampled at that edge, and it enters at the most significant end.
- R3: In the frame, bit 0 is the channel select and bit 1 is the mode bit. Bits 2 to 10 carry delay bits D0 to D8. The bit sent first therefore lands in bit 0 and the bit sent last is D8. When more than 11 bits are shifted, only the last 11 count.
- R4: A strobe with channel select 0 loads the code into channel 0 and leaves channel 1 unchanged.
- R5: A strobe with channel select 1 loads the code into channel 1 and leaves channel 0 unchanged.
- R6: While the strobe is high, the addressed channel follows the frame register, including bits shifted in during the strobe.
- R7: While the strobe is low, serial clock and serial data activity has no effect on either delay code or on the mode flag.
- R8: Every strobe sets the mode flag from the frame's mode bit, whichever channel the frame addresses. A value of 1 selects the cascaded path and 0 selects independent paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_load | input | 1 | Load strobe; transparent while high, freezes on fall |
| dly0 | output | 9 | Delay code for channel 0 |
| dly1 | output | 9 | Delay code for channel 1 |
| cascade | output | 1 | Mode flag: 1 = cascaded path, 0 = independent paths |

## Verification
A corrupted frame register appears only through a strobe, and it shows a few system clocks after the synchronized strobe rises: as a wrong code, as the wrong channel being loaded, or as a wrong mode flag. A holding state stuck in `LD_FOLLOW` shows up as soon as serial bits arrive with the strobe low, because the outputs then move with each shift. The bench therefore loads distinct frames and then shifts more bits without a strobe. It also loads codes while the strobe is held high, sends over-length frames, and gives a strobe after reset with no shifting.

// File: rtl/dlycfg_pkg.sv
package dlycfg_pkg;
    localparam int CODE_W   = 9;
    localparam int FRAME_W  = CODE_W + 2;
    localparam int CHAN_BIT = 0;
    localparam int MODE_BIT = 1;
    localparam int CODE_LSB = 2;

    typedef enum logic [0:0] {
        LD_IDLE   = 1'b0,
        LD_FOLLOW = 1'b1
    } ld_state_t;
endpackage

// File: rtl/dlycfg_sync.sv
module dlycfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/dlycfg_shift.sv
module dlycfg_shift #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    // r2_/r3_: the new bit enters at the MSB, so the first bit sent ends in bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {bit_in, q[W-1:1]};
    end
endmodule

// File: rtl/dlycfg_latch_fsm.sv
module dlycfg_latch_fsm
    import dlycfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [FRAME_W-1:0] frame,
    output logic [CODE_W-1:0]  dly0,
    output logic [CODE_W-1:0]  dly1,
    output logic               cascade,
    output logic               follow
);
    ld_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE:   if (strobe)  state_nx = LD_FOLLOW;
            LD_FOLLOW: if (!strobe) state_nx = LD_IDLE;
            default:   state_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    // r1_ zero defaults; r4_/r5_ steering; r6_ transparency; r8_ mode from every frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly0    <= '0;
            dly1    <= '0;
            cascade <= 1'b0;
        end else if (state == LD_FOLLOW) begin
            cascade <= frame[MODE_BIT];
            if (frame[CHAN_BIT]) dly1 <= frame[CODE_LSB +: CODE_W];
            else                 dly0 <= frame[CODE_LSB +: CODE_W];
        end
    end

    assign follow = (state == LD_FOLLOW);
endmodule

// File: rtl/dlycfg_loader.sv
module dlycfg_loader
    import dlycfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_load,
    output logic [CODE_W-1:0] dly0,
    output logic [CODE_W-1:0] dly1,
    output logic              cascade
);
    logic               clk_lvl, clk_prev, data_lvl, load_lvl, shift_en, follow;
    logic [FRAME_W-1:0] shreg;

    dlycfg_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .din(ser_clk), .level(clk_lvl));
    dlycfg_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .din(ser_data), .level(data_lvl));
    dlycfg_sync #(.STAGES(SYNC_STAGES)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .din(ser_load), .level(load_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_lvl;
    end

    assign shift_en = clk_lvl & ~clk_prev;

    dlycfg_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .bit_in(data_lvl), .q(shreg));

    dlycfg_latch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(load_lvl), .frame(shreg),
        .dly0(dly0), .dly1(dly1), .cascade(cascade), .follow(follow));
endmodule

// File: rtl/dlycfg_loader_chk.sv
module dlycfg_loader_chk
    import dlycfg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CODE_W-1:0]  dly0,
    input logic [CODE_W-1:0]  dly1,
    input logic               cascade,
    input logic               follow,
    input logic               shift_en,
    input logic               data_lvl,
    input logic [FRAME_W-1:0] shreg
);
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shreg[FRAME_W-2:0] == $past(shreg[FRAME_W-1:1]));

    a_r2_shift_takes_bit: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shreg[FRAME_W-1] == $past(data_lvl));

    a_r2_no_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shreg));

    a_r4_chan0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && !shreg[CHAN_BIT]) |=>
            (dly0 == $past(shreg[CODE_LSB +: CODE_W])) && $stable(dly1));

    a_r5_chan1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && shreg[CHAN_BIT]) |=>
            (dly1 == $past(shreg[CODE_LSB +: CODE_W])) && $stable(dly0));

    a_r8_mode_every_frame: assert property (@(posedge clk) disable iff (!rst_n)
        follow |=> cascade == $past(shreg[MODE_BIT]));

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !follow |=> ($stable(dly0) && $stable(dly1) && $stable(cascade)));
endmodule

bind dlycfg_loader dlycfg_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dly0(dly0), .dly1(dly1), .cascade(cascade),
    .follow(follow), .shift_en(shift_en), .data_lvl(data_lvl), .shreg(shreg));

// File: tb/dlycfg_loader_test.sv
module dlycfg_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic [8:0] dly0, dly1;
    logic       cascade;
    int         checks = 0, errors = 0;
    int         e0 = 0, e1 = 0, em = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dlycfg_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load(ser_load), .dly0(dly0), .dly1(dly1), .cascade(cascade));

    // frame = {code[8:0], mode, chan}
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {9'h1A5, 1'b0, 1'b0},
        {9'h05A, 1'b0, 1'b1},
        {9'h1FF, 1'b1, 1'b0},
        {9'h000, 1'b1, 1'b1},
        {9'h001, 1'b0, 1'b1},
        {9'h100, 1'b1, 1'b0}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [10:0] f);
        for (int i = 0; i < 11; i++) send_bit(f[i]);
    endtask

    task automatic strobe();
        ser_load = 1'b1;
        wait_clk(6);
        ser_load = 1'b0;
        wait_clk(6);
    endtask

    task automatic model_load(input logic [10:0] f);
        em = f[1];
        if (f[0]) e1 = f[10:2];
        else      e0 = f[10:2];
    endtask

    task automatic check_all(input string tag);
        check({tag, " dly0"}, dly0, e0);
        check({tag, " dly1"}, dly1, e1);
        check({tag, " mode"}, cascade, em);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: values during and after reset
        wait_clk(3);
        check_all("R1 in reset");
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1 after reset");

        // R3 R4 R5 R8: walk the vector table
        for (int v = 0; v < NV; v++) begin
            send_frame(VEC[v]);
            strobe();
            model_load(VEC[v]);
            check_all("R3/R4/R5/R8 table");
        end

        // R7: shift a full frame with the strobe low, nothing may move
        send_frame({9'h0F0, 1'b0, 1'b1});
        check_all("R7 no strobe");
        send_bit(1'b1);
        send_bit(1'b0);
        check_all("R7 extra bits");

        // R3: over-length frame, only the last 11 bits count
        send_bit(1'b1);
        send_bit(1'b1);
        send_frame({9'h0C3, 1'b1, 1'b0});
        strobe();
        model_load({9'h0C3, 1'b1, 1'b0});
        check_all("R3 over-length");

        // R6: strobe held high while a frame shifts in
        ser_load = 1'b1;
        wait_clk(6);
        send_frame({9'h13C, 1'b0, 1'b1});
        wait_clk(6);
        check("R6 transparent dly1", dly1, 9'h13C);
        check("R6 transparent mode", cascade, 0);
        ser_load = 1'b0;
        wait_clk(6);
        send_frame({9'h0AA, 1'b1, 1'b1});
        check("R7 frozen after fall", dly1, 9'h13C);
        // restore a known state in both channels
        send_frame({9'h011, 1'b0, 1'b0});
        strobe();
        send_frame({9'h022, 1'b1, 1'b1});
        strobe();
        e0 = 9'h011; e1 = 9'h022; em = 1;
        check_all("R4/R5/R8 restore");

        // R1: reset clears loaded values and the frame register
        rst_n = 1'b0;
        wait_clk(2);
        e0 = 0; e1 = 0; em = 0;
        check_all("R1 mid reset");
        rst_n = 1'b1;
        wait_clk(2);
        strobe();
        check_all("R1 cleared frame");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule